// File: doc/BRIEF.md
# Trace Capture Engine

This block records a byte-wide streaming interface (data byte, data-valid, line sync and frame sync) into an on-chip circular buffer. It runs on the stream's own clock and only taps the signals, so the observed logic never waits on it. Software, or a debug transport outside this block, sets a trigger mode and the pre- and post-trigger sample counts. It then pulses an arm command. The block keeps recording until the trigger condition occurs, takes the configured number of further samples, freezes, and raises done.

Triggering can use two stages. With the two-stage option set, a frame-sync rising edge must be seen first. Only then can the selected condition fire. This catches a rare event that follows a common one. Three conditions are available: a marker byte at the end of a burst shortly after a line sync, an over-long gap in valid data, and a frame sync that arrives in the middle of an active line.

After done, a host walks the read index from zero upward. Index zero is the oldest kept pre-trigger sample. A count output says how many pre-trigger samples are valid, which matters when the trigger came early.

Top module: `trace_capture`

## Requirements
- R1: Each probe input passes through one register stage. A stored sample is {hsync, vsync, valid, data} with data in bits [7:0], valid in bit 8, vsync in bit 9 and hsync in bit 10. The sample presented in the same cycle as `cmd_arm` is the first one recorded.
- R2: A `cmd_arm` pulse starts recording. On the next cycle `sts_armed` is 1 and `sts_triggered` and `sts_done` are 0, even if a previous capture had finished.
- R3: Mode 0 (marker) fires on a sample whose valid is 0 and whose data is 0xBC, when the previous sample had valid 1 and the last sample with hsync 1 lies 1 to 3 samples earlier. A distance of 4 does not fire.
- R4: Mode 1 (gap) fires on the (N+1)-th consecutive sample with valid 0, where N is `cfg_gap`. A run of exactly N low samples does not fire.
- R5: Mode 2 (mid-line frame sync) fires on a vsync rising edge when a valid sample has occurred since the last hsync. A vsync edge right after an hsync, with no valid in between, does not fire.
- R6: With `cfg_two_stage` = 1, the selected condition is ignored until a vsync rising edge has been recorded while armed. `sts_stage2` shows that the second stage is open.
- R7: At the trigger, `sts_pre_valid` becomes the smaller of `cfg_pre` and the number of samples recorded since arming. It holds until the next arm.
- R8: `sts_done` is first seen one cycle after the edge that stores the `cfg_post`-th sample following the trigger sample. With `cfg_post` = 0 that edge is the one storing the trigger sample itself. Done then holds until arm or abort.
- R9: After done, `rd_sample` at `rd_idx` = i returns the i-th kept sample, oldest first. Index `sts_pre_valid` is the trigger sample, and the indices run up to `sts_pre_valid` + `cfg_post`.
- R10: `cmd_abort` returns the block to idle. A trigger condition that occurs afterwards causes no trigger and no done.
- R11: While armed or collecting post-trigger samples, one sample is stored every cycle with no stall. Readout stays correct after the buffer has wrapped many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock, also the capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_data | input | 8 | Observed data byte |
| probe_valid | input | 1 | Observed data-valid |
| probe_hsync | input | 1 | Observed line sync |
| probe_vsync | input | 1 | Observed frame sync |
| cmd_arm | input | 1 | Start a new capture (one-cycle pulse) |
| cmd_abort | input | 1 | Return to idle, takes priority over arm |
| cfg_mode | input | 2 | Condition: 0 marker, 1 gap, 2 mid-line frame sync, 3 none |
| cfg_two_stage | input | 1 | Require a vsync rising edge before the condition counts |
| cfg_pre | input | 5 | Pre-trigger samples to keep |
| cfg_post | input | 5 | Samples to take after the trigger sample |
| cfg_gap | input | 8 | Gap threshold N for mode 1 |
| rd_idx | input | 5 | Read index from oldest kept sample |
| rd_sample | output | 11 | Stored sample at the read index |
| sts_armed | output | 1 | Recording and waiting for the trigger |
| sts_stage2 | output | 1 | Armed with the second stage open |
| sts_triggered | output | 1 | Trigger seen since the last arm |
| sts_done | output | 1 | Capture frozen, readout valid |
| sts_pre_valid | output | 5 | Number of valid pre-trigger samples |

## Verification
The bench drives a background stream whose valid drops one cycle in four and whose data never reaches 0xBC. It then injects one genuine trigger pattern and one near-miss decoy for each mode. For the marker mode the decoy has the line sync four samples back instead of three. For the gap mode the decoy is a run exactly one sample short. For the mid-line mode the frame sync follows a line sync with no valid data between them. Each decoy comes earlier than the real event, so a decoy that wrongly fires shows up as an early done and a shifted readout. Further cases cover a decoy that is genuine but arrives before the first stage opens, an arm placed too late to fill the pre-trigger window, a zero post count, a zero pre count, a long run that wraps the buffer, and an abort before the event.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    TRG_MARKER  = 2'd0,
    TRG_GAP     = 2'd1,
    TRG_MIDLINE = 2'd2,
    TRG_NONE    = 2'd3
  } trg_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_POST = 2'd2,
    ST_HOLD = 2'd3
  } cap_state_e;

endpackage

// File: rtl/trc_probe_stage.sv
module trc_probe_stage #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] MARKER = 8'hBC,
  parameter int                HS_WIN = 3,
  parameter int                GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic [GAP_W-1:0]  cfg_gap,
  output logic [DATA_W+2:0] smp,
  output logic              ev_marker,
  output logic              ev_gap,
  output logic              ev_midline,
  output logic              ev_vs_rise
);
  localparam int               AGE_W   = $clog2(HS_WIN + 1);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(HS_WIN);
  localparam logic [GAP_W-1:0] GAP_SAT = '1;

  // one register stage on every probe
  logic [DATA_W-1:0] p_data;
  logic              p_valid, p_hs, p_vs;
  // history of the registered stream
  logic              valid_d, vs_d, line_act;
  logic [AGE_W-1:0]  hs_age;
  logic [GAP_W-1:0]  gap_cnt;

  function automatic logic [AGE_W-1:0] age_next(input logic hs, input logic [AGE_W-1:0] age);
    if (hs)                 return '0;
    else if (age != AGE_SAT) return age + 1'b1;
    else                    return age;
  endfunction

  function automatic logic [GAP_W-1:0] gap_next(input logic vld, input logic [GAP_W-1:0] cnt);
    if (vld)                return '0;
    else if (cnt != GAP_SAT) return cnt + 1'b1;
    else                    return cnt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_data   <= '0;
      p_valid  <= 1'b0;
      p_hs     <= 1'b0;
      p_vs     <= 1'b0;
      valid_d  <= 1'b0;
      vs_d     <= 1'b0;
      line_act <= 1'b0;
      hs_age   <= AGE_SAT;
      gap_cnt  <= '0;
    end else begin
      p_data   <= in_data;
      p_valid  <= in_valid;
      p_hs     <= in_hsync;
      p_vs     <= in_vsync;
      valid_d  <= p_valid;
      vs_d     <= p_vs;
      hs_age   <= age_next(p_hs, hs_age);
      gap_cnt  <= gap_next(p_valid, gap_cnt);
      if (p_hs)         line_act <= 1'b0;
      else if (p_valid) line_act <= 1'b1;
    end
  end

  assign smp        = {p_hs, p_vs, p_valid, p_data};
  // hs_age = distance to last hsync minus one
  assign ev_marker  = valid_d && !p_valid && (p_data == MARKER) && !p_hs && (hs_age < AGE_SAT);
  assign ev_gap     = !p_valid && (gap_cnt == cfg_gap);
  assign ev_vs_rise = p_vs && !vs_d;
  assign ev_midline = ev_vs_rise && line_act;

endmodule

// File: rtl/trc_trigger_sel.sv
module trc_trigger_sel
  import trc_pkg::*;
(
  input  logic [1:0] cfg_mode,
  input  logic       ev_marker,
  input  logic       ev_gap,
  input  logic       ev_midline,
  output logic       hit
);
  always_comb begin
    case (trg_mode_e'(cfg_mode))
      TRG_MARKER:  hit = ev_marker;
      TRG_GAP:     hit = ev_gap;
      TRG_MIDLINE: hit = ev_midline;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/trc_ring_buf.sv
module trc_ring_buf #(
  parameter int DEPTH = 32,
  parameter int SMP_W = 11,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SMP_W-1:0] wr_data,
  output logic [AW-1:0]    wr_ptr,
  input  logic [AW-1:0]    rd_base,
  input  logic [AW-1:0]    rd_idx,
  output logic [SMP_W-1:0] rd_data
);
  logic [SMP_W-1:0] mem [DEPTH];

  // depth is a power of two, so the sum wraps by truncation
  function automatic logic [AW-1:0] ring_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_ptr <= '0;
    else if (wr_en) wr_ptr <= ring_add(wr_ptr, AW'(1));
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[ring_add(rd_base, rd_idx)];

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trc_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          DEPTH  = 32,
  parameter int          HS_WIN = 3,
  parameter int          GAP_W  = 8,
  parameter logic [7:0]  MARKER = 8'hBC,
  localparam int         AW     = $clog2(DEPTH),
  localparam int         SMP_W  = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] probe_data,
  input  logic              probe_valid,
  input  logic              probe_hsync,
  input  logic              probe_vsync,
  input  logic              cmd_arm,
  input  logic              cmd_abort,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_two_stage,
  input  logic [AW-1:0]     cfg_pre,
  input  logic [AW-1:0]     cfg_post,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [AW-1:0]     rd_idx,
  output logic [SMP_W-1:0]  rd_sample,
  output logic              sts_armed,
  output logic              sts_stage2,
  output logic              sts_triggered,
  output logic              sts_done,
  output logic [AW-1:0]     sts_pre_valid
);
  localparam logic [AW-1:0] FILL_MAX = AW'(DEPTH - 1);

  cap_state_e       state;
  logic             stage2_ok;
  logic [AW-1:0]    fill, pre_valid, post_left, trig_addr;

  logic [SMP_W-1:0] smp;
  logic             ev_marker, ev_gap, ev_midline, ev_vs_rise;
  logic             trig_hit;
  logic             fire_evt;
  logic             wr_en;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_base;

  function automatic logic [AW-1:0] pre_take(input logic [AW-1:0] have, input logic [AW-1:0] want);
    return (have < want) ? have : want;
  endfunction

  trc_probe_stage #(
    .DATA_W(DATA_W), .MARKER(DATA_W'(MARKER)), .HS_WIN(HS_WIN), .GAP_W(GAP_W)
  ) u_probe (
    .clk(clk), .rst_n(rst_n),
    .in_data(probe_data), .in_valid(probe_valid),
    .in_hsync(probe_hsync), .in_vsync(probe_vsync),
    .cfg_gap(cfg_gap), .smp(smp),
    .ev_marker(ev_marker), .ev_gap(ev_gap),
    .ev_midline(ev_midline), .ev_vs_rise(ev_vs_rise)
  );

  trc_trigger_sel u_sel (
    .cfg_mode(cfg_mode), .ev_marker(ev_marker), .ev_gap(ev_gap),
    .ev_midline(ev_midline), .hit(trig_hit)
  );

  assign wr_en    = (state == ST_WAIT) || (state == ST_POST);
  assign fire_evt = (state == ST_WAIT) && stage2_ok && trig_hit;
  assign rd_base  = trig_addr - pre_valid;

  trc_ring_buf #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(smp), .wr_ptr(wr_ptr),
    .rd_base(rd_base), .rd_idx(rd_idx), .rd_data(rd_sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      stage2_ok <= 1'b0;
      fill      <= '0;
      pre_valid <= '0;
      post_left <= '0;
      trig_addr <= '0;
    end else if (cmd_abort) begin
      state     <= ST_IDLE;
      stage2_ok <= 1'b0;
    end else if (cmd_arm) begin
      state     <= ST_WAIT;
      stage2_ok <= !cfg_two_stage;
      fill      <= '0;
      pre_valid <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (fire_evt) begin
            trig_addr <= wr_ptr;
            pre_valid <= pre_take(fill, cfg_pre);
            post_left <= cfg_post;
            state     <= (cfg_post == '0) ? ST_HOLD : ST_POST;
          end else begin
            if (ev_vs_rise)        stage2_ok <= 1'b1;
            if (fill != FILL_MAX)  fill      <= fill + 1'b1;
          end
        end
        ST_POST: begin
          post_left <= post_left - 1'b1;
          if (post_left == AW'(1)) state <= ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  assign sts_armed     = (state == ST_WAIT);
  assign sts_stage2    = (state == ST_WAIT) && stage2_ok;
  assign sts_triggered = (state == ST_POST) || (state == ST_HOLD);
  assign sts_done      = (state == ST_HOLD);
  assign sts_pre_valid = pre_valid;

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_arm,
  input logic          cmd_abort,
  input logic [AW-1:0] cfg_pre,
  input logic          sts_armed,
  input logic          sts_stage2,
  input logic          sts_triggered,
  input logic          sts_done,
  input logic [AW-1:0] sts_pre_valid,
  input logic          wr_en,
  input logic [AW-1:0] wr_ptr
);
  assert_arm_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_arm && !cmd_abort) |=> (sts_armed && !sts_triggered && !sts_done));

  assert_stage_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_armed && !sts_stage2) |=> !sts_triggered);

  assert_pre_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_triggered) |-> (sts_pre_valid <= $past(cfg_pre)));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_done && !cmd_arm && !cmd_abort) |=> (sts_done && $stable(sts_pre_valid)));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> (!sts_armed && !sts_triggered && !sts_done));

  assert_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

endmodule

bind trace_capture trace_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_abort(cmd_abort),
  .cfg_pre(cfg_pre), .sts_armed(sts_armed), .sts_stage2(sts_stage2),
  .sts_triggered(sts_triggered), .sts_done(sts_done),
  .sts_pre_valid(sts_pre_valid), .wr_en(wr_en), .wr_ptr(wr_ptr)
);

// File: tb/trace_capture_bench.sv
module trace_capture_bench;
  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  probe_data;
  logic        probe_valid, probe_hsync, probe_vsync;
  logic        cmd_arm, cmd_abort, cfg_two_stage;
  logic [1:0]  cfg_mode;
  logic [AW-1:0] cfg_pre, cfg_post, rd_idx;
  logic [7:0]  cfg_gap;
  logic [10:0] rd_sample;
  logic        sts_armed, sts_stage2, sts_triggered, sts_done;
  logic [AW-1:0] sts_pre_valid;

  always #4 clk = ~clk;

  trace_capture u_trace_capture (
    .clk(clk), .rst_n(rst_n),
    .probe_data(probe_data), .probe_valid(probe_valid),
    .probe_hsync(probe_hsync), .probe_vsync(probe_vsync),
    .cmd_arm(cmd_arm), .cmd_abort(cmd_abort),
    .cfg_mode(cfg_mode), .cfg_two_stage(cfg_two_stage),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_gap(cfg_gap),
    .rd_idx(rd_idx), .rd_sample(rd_sample),
    .sts_armed(sts_armed), .sts_stage2(sts_stage2),
    .sts_triggered(sts_triggered), .sts_done(sts_done),
    .sts_pre_valid(sts_pre_valid)
  );

  // fields: mode, two_stage, pre, post, gap_n, arm, trig, decoy, stage1_vs, decoy_genuine
  localparam int NSCN = 7;
  localparam int SCN [NSCN][10] = '{
    '{0, 0,  8,  6, 0, 10,  40,  25,  0, 0},
    '{0, 0, 12,  4, 0, 30,  36,  20,  0, 0},
    '{1, 0, 10, 10, 5, 10,  60,  30,  0, 0},
    '{2, 0, 16,  0, 0, 10,  50,  30,  0, 0},
    '{0, 1, 10,  8, 0, 10,  60,  30, 40, 1},
    '{1, 0, 20,  9, 2,  5, 150, 100,  0, 0},
    '{2, 0,  0,  1, 0, 10,  40,  20,  0, 0}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [10:0] log_s [256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns {hsync, vsync, valid, data}
  function automatic logic [10:0] stim(input int e, input int k);
    logic hs, vs, vl;
    logic [7:0] d;
    int md, n, t, dc, off;
    md = SCN[e][0]; n = SCN[e][4]; t = SCN[e][6]; dc = SCN[e][7];
    hs = 1'b0; vs = 1'b0; vl = (k % 4) != 3; d = {1'b0, 7'(k)};
    if (md == 0) begin
      off = (SCN[e][9] != 0) ? 3 : 4;
      if (k == t - 3 || k == dc - off) hs = 1'b1;
      if (k == t - 1 || k == dc - 1) vl = 1'b1;
      if (k == t || k == dc) begin vl = 1'b0; d = 8'hBC; end
    end else if (md == 1) begin
      if (k >= dc && k <= dc + n - 1) vl = 1'b0;
      if (k == dc - 1 || k == dc + n) vl = 1'b1;
      if (k >= t - n && k <= t) vl = 1'b0;
      if (k == t - n - 1) vl = 1'b1;
    end else if (md == 2) begin
      if (k == t || k == dc) vs = 1'b1;
      if (k == dc - 1) hs = 1'b1;
    end
    if (SCN[e][8] != 0 && k == SCN[e][8]) vs = 1'b1;
    return {hs, vs, vl, d};
  endfunction

  function automatic string tag_of(input int e);
    if (e == 5)            return "R11";
    if (SCN[e][1] != 0)    return "R6";
    if (SCN[e][0] == 0)    return "R3";
    if (SCN[e][0] == 1)    return "R4";
    return "R5";
  endfunction

  task automatic drive(input logic [10:0] s, input bit arm, input bit abort);
    {probe_hsync, probe_vsync, probe_valid, probe_data} = s;
    cmd_arm = arm;
    cmd_abort = abort;
  endtask

  task automatic run_scn(input int e);
    int arm, trig, post, pre, len, first_done, pv;
    arm = SCN[e][5]; trig = SCN[e][6]; post = SCN[e][3]; pre = SCN[e][2];
    len = trig + post + 6;
    first_done = -1;
    pv = (trig - arm < pre) ? trig - arm : pre;
    @(negedge clk);
    cfg_mode = 2'(SCN[e][0]); cfg_two_stage = SCN[e][1] != 0;
    cfg_pre = AW'(pre); cfg_post = AW'(post); cfg_gap = 8'(SCN[e][4]);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k > arm && sts_done && first_done < 0) first_done = k;
      if (k == arm + 1)
        check(sts_armed && !sts_done && !sts_triggered, "R2", {sts_armed, sts_triggered, sts_done}, 3'b100);
      log_s[k] = stim(e, k);
      drive(log_s[k], k == arm, 1'b0);
    end
    check(sts_triggered, tag_of(e), sts_triggered, 1);
    check(first_done == trig + 2 + post, "R8", first_done, trig + 2 + post);
    check(int'(sts_pre_valid) == pv, "R7", sts_pre_valid, pv);
    for (int i = 0; i <= pv + post; i++) begin
      rd_idx = AW'(i);
      #1;
      check(rd_sample == log_s[trig - pv + i], "R9 R1", rd_sample, log_s[trig - pv + i]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(11'd0, 1'b0, 1'b0);
    cfg_mode = 2'd0; cfg_two_stage = 1'b0; cfg_pre = '0; cfg_post = '0;
    cfg_gap = 8'd0; rd_idx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!sts_armed && !sts_triggered && !sts_done, "R2 reset", {sts_armed, sts_triggered, sts_done}, 0);
    check(sts_pre_valid == '0, "R7 reset", sts_pre_valid, 0);

    // table of scenarios
    for (int e = 0; e < NSCN; e++) run_scn(e);

    // abort before the trigger pattern (scenario 0 stream, trigger at 40)
    @(negedge clk);
    cfg_mode = 2'd0; cfg_two_stage = 1'b0; cfg_pre = AW'(4); cfg_post = AW'(2);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k == 21)
        check(!sts_armed && !sts_triggered && !sts_done, "R10", {sts_armed, sts_triggered, sts_done}, 0);
      drive(stim(0, k), k == 10, k == 20);
    end
    check(!sts_triggered && !sts_done, "R10", {sts_triggered, sts_done}, 0);

    // mode 3 selects no condition: marker pattern must not fire
    cfg_mode = 2'd3;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      drive(stim(0, k), k == 10, 1'b0);
    end
    check(sts_armed && !sts_triggered, "R3 mode3", {sts_armed, sts_triggered}, 2'b10);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule